// File: doc/BRIEF.md
# Drift-Compensated Time-of-Day Counter

This block keeps a 64-bit nanosecond time value that steps forward by a fixed nominal amount (parameter `INC_NS`) on every clock. A rate corrector trims the count: at a programmable interval it makes one clock's step a few nanoseconds longer or shorter, so the counter can be pulled towards a reference clock without changing its nominal increment. Software controls everything through a simple synchronous register port with one write channel and one read channel.

Software can stop and restart the counter with command codes, and it loads a new time in two 32-bit halves while the counter is stopped. It reads the time as two halves, low half first. Reading the low half captures the high half into a shadow register, so the pair read back always belongs to the same instant. The rate corrector has its own hold control. Its configuration word can only be changed while the corrector is held, and the corrector starts counting when the hold is released.

The corrector state machine has three states. `DR_OFF` means no corrections are made. `DR_HELD` means the hold is asserted and the interval accumulator is cleared. `DR_COUNT` means nanoseconds are being accumulated towards the next correction. The transitions are: `DR_OFF`→`DR_HELD` when the hold is set; `DR_HELD`→`DR_COUNT` when the hold is released with a non-zero magnitude; `DR_HELD`→`DR_OFF` when it is released with a zero magnitude; `DR_COUNT`→`DR_HELD` when the hold is set. The counter state machine has two states, `CT_RUN` and `CT_PAUSED`. Command code 2 moves it `CT_RUN`→`CT_PAUSED`, and code 4 moves it `CT_PAUSED`→`CT_RUN`.

Top module: `tsc_top`

## Requirements
- R1: After reset the time is 0, the counter is running, the corrector is in `DR_OFF`, and both the configuration word and the hold control read 0.
- R2: While running with no correction due, the time increases by exactly `INC_NS` on every clock.
- R3: Writing 2 to the command register (offset 2) pauses the counter and writing 4 resumes it. Any other value is ignored. A read of offset 2 returns 2 while paused and 4 while running.
- R4: Writes to the low-half load register (offset 3) and the high-half load register (offset 4) replace that half of the time only while paused. While running they are ignored.
- R5: The configuration word (offset 0) has the direction in bit 31 (1 = add, 0 = subtract), the magnitude in ns in bits 30:28, and the period in 16 ns quanta in bits 27:0. A write is accepted only while the hold control is 1. The word reads back at offset 0.
- R6: Writing 1 to bit 0 of the hold control (offset 1) holds the corrector, and offset 1 then reads 1. While held, no correction is made and the time advances by `INC_NS` per clock.
- R7: In `DR_COUNT`, each running clock adds `INC_NS` to an accumulator. On the clock where the sum reaches 16·period+8 or more, the step is `INC_NS`+magnitude (add) or `INC_NS`−magnitude (subtract), and the accumulator restarts at 0.
- R8: A magnitude of 0 in the configuration word, including an all-zero word, produces no correction.
- R9: Read data appears on the clock after the read strobe. A read of offset 5 returns the low 32 bits of the time and latches the high 32 bits into a shadow register. A read of offset 6 returns that shadow.
- R10: While paused, neither the time nor the corrector's accumulator advances, and no correction is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Read data, valid the clock after the strobe |

## Verification
The bench targets the corrector's interval edge cases. With a period of 0 the interval is shorter than one clock's step, so every clock must be corrected and the accumulator must not run away. A short period must fire on exactly every second or third clock. A design that compares with the wrong bound, or that keeps a remainder, shifts these positions and ends at a different time. The split read is tested across a carry from the low half into the high half: a design without the shadow returns a high half one greater. Commands and loads that must be ignored, such as an unknown command code, a load while running or a configuration write while not held, are each followed by a read-back that would expose a change.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int REG_W    = 32;
    localparam int TIME_W   = 2 * REG_W;
    localparam int ADDR_W   = 3;
    localparam int PERIOD_W = 28;
    localparam int MAG_W    = 3;
    localparam int ACC_W    = 32;

    localparam logic [REG_W-1:0] CMD_PAUSE  = 32'd2;
    localparam logic [REG_W-1:0] CMD_RESUME = 32'd4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DCFG = 3'd0,
        REG_DRST = 3'd1,
        REG_CTRL = 3'd2,
        REG_LDLO = 3'd3,
        REG_LDHI = 3'd4,
        REG_RDLO = 3'd5,
        REG_RDHI = 3'd6,
        REG_NONE = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        DR_OFF   = 2'd0,
        DR_HELD  = 2'd1,
        DR_COUNT = 2'd2
    } drift_state_e;

    typedef enum logic {
        CT_RUN    = 1'b0,
        CT_PAUSED = 1'b1
    } ctr_state_e;

    typedef struct packed {
        logic                add;
        logic [MAG_W-1:0]    mag;
        logic [PERIOD_W-1:0] period;
    } drift_cfg_t;
endpackage

// File: rtl/tsc_ctl.sv
module tsc_ctl
    import tsc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    output drift_cfg_t            cfg,
    output logic                  drift_hold,
    output logic                  paused,
    output logic                  ld_lo,
    output logic                  ld_hi
);
    ctr_state_e state_q, state_d;
    reg_addr_e  waddr;

    assign waddr = reg_addr_e'(wr_addr);

    // counter state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CT_RUN;
        else        state_q <= state_d;
    end

    // counter next state
    always_comb begin
        state_d = state_q;
        if (wr_en && waddr == REG_CTRL) begin
            unique case (state_q)
                CT_RUN:    if (wr_data == CMD_PAUSE)  state_d = CT_PAUSED;
                CT_PAUSED: if (wr_data == CMD_RESUME) state_d = CT_RUN;
            endcase
        end
    end

    // counter outputs
    always_comb begin
        paused = (state_q == CT_PAUSED);
        ld_lo  = wr_en && (waddr == REG_LDLO) && paused;
        ld_hi  = wr_en && (waddr == REG_LDHI) && paused;
    end

    // configuration and hold control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            drift_hold <= 1'b0;
        end else if (wr_en) begin
            if (waddr == REG_DRST) drift_hold <= wr_data[0];
            if (waddr == REG_DCFG && drift_hold) cfg <= drift_cfg_t'(wr_data);
        end
    end
endmodule

// File: rtl/tsc_drift.sv
module tsc_drift
    import tsc_pkg::*;
#(
    parameter int INC_NS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic                advance,
    input  logic [PERIOD_W-1:0] period,
    input  logic [MAG_W-1:0]    mag,
    output logic                fire,
    output drift_state_e        state
);
    localparam int SUM_W = ACC_W + 1;

    drift_state_e        state_d;
    logic [ACC_W-1:0]    acc_q, acc_d;
    logic [SUM_W-1:0]    sum;
    logic [ACC_W-1:0]    interval;
    logic                due;

    assign interval = {period, 4'b0000} + ACC_W'(8);
    assign sum      = {1'b0, acc_q} + SUM_W'(INC_NS);
    assign due      = (sum >= {1'b0, interval});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DR_OFF;
            acc_q <= '0;
        end else begin
            state <= state_d;
            acc_q <= acc_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            DR_OFF:   if (hold) state_d = DR_HELD;
            DR_HELD:  if (!hold) state_d = (mag != '0) ? DR_COUNT : DR_OFF;
            DR_COUNT: if (hold) state_d = DR_HELD;
            default:  state_d = DR_OFF;
        endcase
    end

    // outputs and accumulator
    always_comb begin
        fire  = 1'b0;
        acc_d = '0;
        unique case (state)
            DR_OFF, DR_HELD: acc_d = '0;
            DR_COUNT: begin
                if (hold) begin
                    acc_d = '0;
                end else if (!advance) begin
                    acc_d = acc_q;
                end else if (due) begin
                    fire  = 1'b1;
                    acc_d = '0;
                end else begin
                    acc_d = sum[ACC_W-1:0];
                end
            end
            default: acc_d = '0;
        endcase
    end
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
    import tsc_pkg::*;
#(
    parameter int INC_NS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              fire,
    input  logic              add,
    input  logic [MAG_W-1:0]  mag,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [REG_W-1:0]  ld_data,
    output logic [TIME_W-1:0] time_q
);
    localparam logic [TIME_W-1:0] BASE = TIME_W'(INC_NS);

    logic [TIME_W-1:0] step;

    always_comb begin
        step = BASE;
        if (fire) step = add ? BASE + TIME_W'(mag) : BASE - TIME_W'(mag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       time_q <= '0;
        else if (ld_lo)   time_q[REG_W-1:0] <= ld_data;
        else if (ld_hi)   time_q[TIME_W-1:REG_W] <= ld_data;
        else if (advance) time_q <= time_q + step;
    end
endmodule

// File: rtl/tsc_top.sv
module tsc_top
    import tsc_pkg::*;
#(
    parameter int INC_NS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data
);
    drift_cfg_t         cfg;
    logic               drift_hold;
    logic               paused;
    logic               ld_lo, ld_hi;
    logic               fire;
    drift_state_e       dstate;
    logic [TIME_W-1:0]  time_now;
    logic [REG_W-1:0]   shadow_hi;

    tsc_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cfg        (cfg),
        .drift_hold (drift_hold),
        .paused     (paused),
        .ld_lo      (ld_lo),
        .ld_hi      (ld_hi)
    );

    tsc_drift #(.INC_NS(INC_NS)) u_drift (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (drift_hold),
        .advance (!paused),
        .period  (cfg.period),
        .mag     (cfg.mag),
        .fire    (fire),
        .state   (dstate)
    );

    tsc_counter #(.INC_NS(INC_NS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (!paused),
        .fire    (fire),
        .add     (cfg.add),
        .mag     (cfg.mag),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_data (wr_data),
        .time_q  (time_now)
    );

    // read port with coherent high-half shadow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            shadow_hi <= '0;
        end else if (rd_en) begin
            case (reg_addr_e'(rd_addr))
                REG_DCFG: rd_data <= cfg;
                REG_DRST: rd_data <= {{(REG_W-1){1'b0}}, drift_hold};
                REG_CTRL: rd_data <= paused ? CMD_PAUSE : CMD_RESUME;
                REG_RDLO: begin
                    rd_data   <= time_now[REG_W-1:0];
                    shadow_hi <= time_now[TIME_W-1:REG_W];
                end
                REG_RDHI: rd_data <= shadow_hi;
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk
    import tsc_pkg::*;
#(
    parameter int INC_NS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    input  logic              paused,
    input  logic              fire,
    input  logic              drift_hold,
    input  drift_cfg_t        cfg,
    input  logic [TIME_W-1:0] time_now,
    input  logic [REG_W-1:0]  shadow_hi
);
    logic              loading;
    logic [TIME_W-1:0] corr_step;

    assign loading   = wr_en && (wr_addr == REG_LDLO || wr_addr == REG_LDHI);
    assign corr_step = cfg.add ? TIME_W'(INC_NS) + TIME_W'(cfg.mag)
                               : TIME_W'(INC_NS) - TIME_W'(cfg.mag);

    // R10
    paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused && !loading |=> $stable(time_now));

    // R10
    paused_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !fire);

    // R2
    nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !paused && !fire |=> time_now == $past(time_now) + TIME_W'(INC_NS));

    // R7
    corr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> time_now == $past(time_now) + $past(corr_step));

    // R8
    zero_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mag == '0 |-> !fire);

    // R6
    held_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drift_hold |-> !fire);

    // R5
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drift_hold |=> $stable(cfg));

    // R9
    shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == REG_RDLO |=> shadow_hi == $past(time_now[TIME_W-1:REG_W]));
endmodule

bind tsc_top tsc_chk #(.INC_NS(INC_NS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .paused     (paused),
    .fire       (fire),
    .drift_hold (drift_hold),
    .cfg        (cfg),
    .time_now   (time_now),
    .shadow_hi  (shadow_hi)
);

// File: tb/tsc_top_tb.sv
module tsc_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int INC       = 16;

    typedef struct packed {
        logic [31:0] cfg;
        logic [7:0]  n_adv;
        logic [31:0] exp_lo;
    } vec_t;

    // R7 / R8 vectors: config word, running clocks, expected final time
    localparam vec_t VECS [7] = '{
        '{32'hB000_0002, 8'd10, 32'd169},
        '{32'h5000_0000, 8'd10, 32'd110},
        '{32'hF000_0007, 8'd10, 32'd167},
        '{32'h1000_0001, 8'd10, 32'd155},
        '{32'h8FFF_FFFF, 8'd10, 32'd160},
        '{32'h0000_0000, 8'd10, 32'd160},
        '{32'hA000_0100, 8'd10, 32'd160}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] v, t0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_top #(.INC_NS(INC)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd5, v); check("R1 time lo", v, 32'd0);
        rd(3'd6, v); check("R1 time hi", v, 32'd0);
        rd(3'd0, v); check("R1 cfg", v, 32'd0);
        rd(3'd1, v); check("R1 hold", v, 32'd0);
        rd(3'd2, v); check("R1 running", v, 32'd4);

        // R2 nominal advance
        wr(3'd2, 32'd2);
        rd(3'd5, t0);
        wr(3'd2, 32'd4);
        idle(4);
        wr(3'd2, 32'd2);
        rd(3'd5, v); check("R2 five steps", v - t0, 32'd80);

        // R3 unknown command ignored, pause state visible
        wr(3'd2, 32'd3);
        idle(2);
        rd(3'd2, v); check("R3 still paused", v, 32'd2);
        rd(3'd5, v); check("R3 time frozen", v, t0 + 32'd80);

        // R4 load while paused, ignored while running
        wr(3'd3, 32'h0000_0100);
        wr(3'd4, 32'h0000_0005);
        rd(3'd5, v); check("R4 load lo", v, 32'h0000_0100);
        rd(3'd6, v); check("R4 load hi", v, 32'h0000_0005);
        wr(3'd2, 32'd4);
        wr(3'd4, 32'h0000_0000);
        wr(3'd2, 32'd2);
        rd(3'd5, v); check("R4 lo after run", v, 32'h0000_0120);
        rd(3'd6, v); check("R4 hi load ignored", v, 32'h0000_0005);

        // R9 coherent split read across a carry
        wr(3'd3, 32'hFFFF_FFF0);
        wr(3'd4, 32'h0000_0000);
        wr(3'd2, 32'd4);
        rd(3'd5, v); check("R9 lo before carry", v, 32'hFFFF_FFF0);
        rd(3'd6, v); check("R9 shadow hi", v, 32'h0000_0000);
        wr(3'd2, 32'd2);
        rd(3'd5, v); check("R9 lo after carry", v, 32'h0000_0020);
        rd(3'd6, v); check("R9 hi after carry", v, 32'h0000_0001);

        // R6 held corrector makes no correction
        wr(3'd1, 32'd1);
        rd(3'd1, v); check("R6 hold reads 1", v, 32'd1);
        wr(3'd0, 32'hF000_0000);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        wr(3'd2, 32'd4);
        idle(9);
        wr(3'd2, 32'd2);
        rd(3'd5, v); check("R6 no correction while held", v, 32'd160);

        // R5 configuration ignored when not held
        wr(3'd1, 32'd0);
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, v); check("R5 cfg locked", v, 32'hF000_0000);

        // R7 / R8 vector table
        for (int i = 0; i < 7; i++) begin
            wr(3'd2, 32'd2);
            wr(3'd1, 32'd1);
            wr(3'd0, VECS[i].cfg);
            rd(3'd0, v); check("R5 cfg readback", v, VECS[i].cfg);
            wr(3'd1, 32'd0);
            wr(3'd3, 32'd0);
            wr(3'd4, 32'd0);
            wr(3'd2, 32'd4);
            idle(int'(VECS[i].n_adv) - 1);
            wr(3'd2, 32'd2);
            // R10 paused: time stays put across idle clocks
            idle(3);
            rd(3'd5, v);
            if (VECS[i].cfg[30:28] == 3'd0)
                check("R8 no drift", v, VECS[i].exp_lo);
            else
                check("R7 drift result", v, VECS[i].exp_lo);
            rd(3'd6, v); check("R10 hi zero", v, 32'd0);
        end

        finish_run();
    end
endmodule